// File: doc/BRIEF.md
# Serial Flash Page Programmer

This block programs a serial NOR flash over single-wire SPI under control of a small register port. Software loads a program opcode and a 3- or 4-byte target address into byte registers, then starts a write by setting the go bit of the command register. The block opens one chip-select window and shifts out the opcode, then the address most significant byte first, then the data. It closes the window when the last bit is sent and clears the go bit on its own, so software polls that bit to find out when the write is done.

There are two data paths. In byte mode, one byte from a write-data register follows the address. In page mode, which software turns on with a buffer-enable request bit, exactly 128 bytes follow. They come from a 32-word queue that software fills through a page data port, and each word is consumed least significant byte first. The buffer-enable bit reads back its effective value. That value follows the request one clock later, and only while no write is running, so software polls it until it matches before it relies on the mode. A page-mode start with an incomplete queue is refused. The queue is then emptied and a sticky error flag is raised.

Two configuration bits, which disable automatic write-enable and automatic status polling, are kept for software. In this build they do not change the wire sequence.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, chip select (active low) is high, the serial clock is low, the go/busy bit (command register 0, bit 4) is 0, and the config register (1) and status register (9) read 0.
- R2: Config bit 0 (buffer enable) reads 0 in the cycle right after a write requests 1, and reads the requested value from the following cycle on, while idle. Clearing it behaves the same way.
- R3: Config bits 7 (no auto write-enable), 5 (no auto status poll) and 2 (4-byte address) read back as written.
- R4: A byte-mode start with config bit 2 clear sends five bytes in one chip-select window: opcode (register 2), address high (register 5), middle (4), low (3), then the write-data byte (register 7).
- R5: With config bit 2 set, address byte 3 (register 6) is sent first among the address bytes, so the window carries 4 address bytes.
- R6: A page-mode start sends exactly 128 data bytes after the address. Each queued word is consumed bits 7:0 first and bits 31:24 last, and words go in the order they were pushed through register 8.
- R7: Wire timing is SPI mode 0 at half the clock rate. Chip select goes low in the cycle after the go write. Each bit is presented for two cycles, with the serial clock low in the first and high in the second, MSB first. Chip select rises after 16 cycles per byte.
- R8: The go bit reads 1 from the cycle after a start until chip select rises, and reads 0 from then on.
- R9: A page-mode start with fewer than 32 queued words sends nothing, sets status bit 0, and empties the queue (status bits 13:8 hold the queue count). Writing 1 to status bit 0 clears the flag.
- R10: A go write while a transfer is running is ignored: the running window keeps its length and no second window follows.
- R11: A push to the page data port while 32 words are queued is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |

## Verification
Byte mode is run with 3-byte and then 4-byte addressing. Comparing the two windows shows whether address byte 3 is placed and ordered correctly, and whether the window length follows the mode bit. Page mode is run twice with different word patterns, one of them with 33 pushes. These runs separate lane order from word order and show whether an overflowing push is dropped. A short queue, a go write in the middle of a transfer, and both edges of the buffer-enable handshake round out the set. Every cycle inside a window is compared against a behavioural queue model of the expected bit stream.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  localparam logic [3:0] RA_CMD  = 4'd0;
  localparam logic [3:0] RA_CFG  = 4'd1;
  localparam logic [3:0] RA_OPC  = 4'd2;
  localparam logic [3:0] RA_AD0  = 4'd3;
  localparam logic [3:0] RA_AD1  = 4'd4;
  localparam logic [3:0] RA_AD2  = 4'd5;
  localparam logic [3:0] RA_AD3  = 4'd6;
  localparam logic [3:0] RA_WDAT = 4'd7;
  localparam logic [3:0] RA_PAGE = 4'd8;
  localparam logic [3:0] RA_STAT = 4'd9;

  localparam int CMD_GO_BIT     = 4;
  localparam int CFG_BUF_BIT    = 0;
  localparam int CFG_A4_BIT     = 2;
  localparam int CFG_NOPOLL_BIT = 5;
  localparam int CFG_NOWREN_BIT = 7;
  localparam int STAT_ERR_BIT   = 0;
  localparam int STAT_CNT_LSB   = 8;
endpackage

// File: rtl/fpp_word_fifo.sv
module fpp_word_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH)) && !flush_i;
  assign do_pop  = pop_i && (cnt_q != '0) && !flush_i;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  assign head_o = mem_q[rp_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fpp_spi_shift.sv
module fpp_spi_shift #(
  parameter int BYTE_W = 8,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              more_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              take_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o
);
  logic              active_q, phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              last_bit;

  assign last_bit = active_q && phase_q && (bit_q == BIT_W'(BYTE_W - 1));
  assign take_o   = start_i || (last_bit && more_i);
  assign done_o   = last_bit && !more_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      bit_q    <= '0;
      sh_q     <= byte_i;
    end else if (active_q) begin
      phase_q <= !phase_q;
      if (phase_q) begin
        if (last_bit) begin
          if (more_i) begin
            sh_q  <= byte_i;
            bit_q <= '0;
          end else begin
            active_q <= 1'b0;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign cs_no  = !active_q;
  assign sck_o  = active_q && phase_q;
  assign mosi_o = active_q && sh_q[BYTE_W-1];
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import fpp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int WORD_W     = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        spi_sck_o,
  output logic        spi_cs_no,
  output logic        spi_mosi_o
);
  localparam int LANES      = WORD_W / 8;
  localparam int LANE_W     = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int FIFO_DEPTH = PAGE_BYTES / LANES;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W      = $clog2(PAGE_BYTES + 6);
  localparam int ADR_BYTES  = 4;

  logic [7:0]              opc_q, wdat_q;
  logic [ADR_BYTES-1:0][7:0] adr_q;
  logic buf_req_q, buf_en_q, a4_q, nopoll_q, nowren_q;
  logic err_q, busy_q, x_buf_q, x_a4_q;
  logic [IDX_W-1:0] idx_q;

  logic              go_req, start, fail, fifo_full, push, pop;
  logic [WORD_W-1:0] fifo_head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              take, done, more, in_addr;
  logic [IDX_W-1:0]  alen, n_bytes;
  logic [LANE_W-1:0] lane;
  logic [1:0]        apos;
  logic [7:0]        tx_byte;

  assign fifo_full = (fifo_cnt == CNT_W'(FIFO_DEPTH));
  assign go_req    = reg_we_i && (reg_addr_i == RA_CMD) && reg_wdata_i[CMD_GO_BIT] && !busy_q;
  assign start     = go_req && (!buf_en_q || fifo_full);
  assign fail      = go_req && buf_en_q && !fifo_full;
  assign push      = reg_we_i && (reg_addr_i == RA_PAGE);

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q     <= '0;
      wdat_q    <= '0;
      adr_q     <= '0;
      buf_req_q <= 1'b0;
      a4_q      <= 1'b0;
      nopoll_q  <= 1'b0;
      nowren_q  <= 1'b0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        RA_CFG: begin
          buf_req_q <= reg_wdata_i[CFG_BUF_BIT];
          a4_q      <= reg_wdata_i[CFG_A4_BIT];
          nopoll_q  <= reg_wdata_i[CFG_NOPOLL_BIT];
          nowren_q  <= reg_wdata_i[CFG_NOWREN_BIT];
        end
        RA_OPC:  opc_q    <= reg_wdata_i[7:0];
        RA_AD0:  adr_q[0] <= reg_wdata_i[7:0];
        RA_AD1:  adr_q[1] <= reg_wdata_i[7:0];
        RA_AD2:  adr_q[2] <= reg_wdata_i[7:0];
        RA_AD3:  adr_q[3] <= reg_wdata_i[7:0];
        RA_WDAT: wdat_q   <= reg_wdata_i[7:0];
        default: ;
      endcase
    end
  end

  // control state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_en_q <= 1'b0;
      err_q    <= 1'b0;
      busy_q   <= 1'b0;
      x_buf_q  <= 1'b0;
      x_a4_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      if (!busy_q) buf_en_q <= buf_req_q;  // mode change only between transfers
      if (fail) err_q <= 1'b1;
      else if (reg_we_i && (reg_addr_i == RA_STAT) && reg_wdata_i[STAT_ERR_BIT]) err_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        x_buf_q <= buf_en_q;
        x_a4_q  <= a4_q;
        idx_q   <= IDX_W'(1);
      end else begin
        if (done) busy_q <= 1'b0;
        if (take) idx_q <= idx_q + 1'b1;
      end
    end
  end

  // byte sequencing: opcode, address MSB first, data
  assign alen    = x_a4_q ? IDX_W'(4) : IDX_W'(3);
  assign n_bytes = IDX_W'(1) + alen + (x_buf_q ? IDX_W'(PAGE_BYTES) : IDX_W'(1));
  assign more    = (idx_q != n_bytes);
  assign in_addr = (idx_q != '0) && (idx_q <= alen);
  assign apos    = 2'(alen - idx_q);
  assign lane    = LANE_W'(idx_q - alen - IDX_W'(1));

  always_comb begin
    if (start)        tx_byte = opc_q;
    else if (in_addr) tx_byte = adr_q[apos];
    else if (x_buf_q) tx_byte = fifo_head[8*lane +: 8];
    else              tx_byte = wdat_q;
  end

  assign pop = take && !start && !in_addr && x_buf_q && (lane == LANE_W'(LANES - 1));

  fpp_word_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (fail),
    .push_i  (push),
    .wdata_i (reg_wdata_i[WORD_W-1:0]),
    .pop_i   (pop),
    .head_o  (fifo_head),
    .cnt_o   (fifo_cnt)
  );

  fpp_spi_shift #(.BYTE_W(8)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .more_i  (more),
    .byte_i  (tx_byte),
    .take_o  (take),
    .done_o  (done),
    .sck_o   (spi_sck_o),
    .cs_no   (spi_cs_no),
    .mosi_o  (spi_mosi_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CMD: reg_rdata_o[CMD_GO_BIT] = busy_q;
      RA_CFG: begin
        reg_rdata_o[CFG_BUF_BIT]    = buf_en_q;
        reg_rdata_o[CFG_A4_BIT]     = a4_q;
        reg_rdata_o[CFG_NOPOLL_BIT] = nopoll_q;
        reg_rdata_o[CFG_NOWREN_BIT] = nowren_q;
      end
      RA_OPC:  reg_rdata_o[7:0] = opc_q;
      RA_AD0:  reg_rdata_o[7:0] = adr_q[0];
      RA_AD1:  reg_rdata_o[7:0] = adr_q[1];
      RA_AD2:  reg_rdata_o[7:0] = adr_q[2];
      RA_AD3:  reg_rdata_o[7:0] = adr_q[3];
      RA_WDAT: reg_rdata_o[7:0] = wdat_q;
      RA_STAT: begin
        reg_rdata_o[STAT_ERR_BIT] = err_q;
        reg_rdata_o[STAT_CNT_LSB +: CNT_W] = fifo_cnt;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             spi_cs_no,
  input logic             spi_sck_o,
  input logic             busy_q,
  input logic             err_q,
  input logic             fail,
  input logic [CNT_W-1:0] fifo_cnt
);
  a_r7_cs_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_no |-> busy_q);

  a_r7_sck_inside_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> !spi_cs_no);

  a_r7_sck_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spi_cs_no && !$past(spi_cs_no)) |-> (spi_sck_o != $past(spi_sck_o)));

  a_r8_idle_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> spi_cs_no);

  a_r9_short_queue_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail |=> (err_q && spi_cs_no && (fifo_cnt == '0)));

  a_r11_queue_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));
endmodule

bind flash_page_prog fpp_checker #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_fpp_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .spi_cs_no (spi_cs_no),
  .spi_sck_o (spi_sck_o),
  .busy_q    (busy_q),
  .err_q     (err_q),
  .fail      (fail),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/test_flash_page_prog.sv
`timescale 1ns/1ps
module test_flash_page_prog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, cs_n, mosi;

  int vectors = 0;
  int errors  = 0;
  logic [7:0]  exp_q[$];
  logic [31:0] model_fifo[$];

  always #2.5 clk = ~clk;

  flash_page_prog i_flash_page_prog (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic push_word(logic [31:0] w);
    wr(4'd8, w);
    if (model_fifo.size() < 32) model_fifo.push_back(w); // R11 model
  endtask

  task automatic load_page_bytes();
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = model_fifo.pop_front();
      for (int l = 0; l < 4; l++) exp_q.push_back(w[8*l +: 8]);
    end
  endtask

  // Called right after the go write; compares every cycle of the window.
  task automatic run_xfer(string req, bit inject);
    int n;
    n = exp_q.size();
    addr = 4'd0;
    for (int t = 0; t < 16 * n; t++) begin
      logic [7:0] b;
      b = exp_q[t / 16];
      #1;
      chk({req, " R7 cs"}, {31'd0, cs_n}, 32'd0);
      chk({req, " R7 sck"}, {31'd0, sck}, {31'd0, 1'(t % 2)});
      chk({req, " R7 mosi"}, {31'd0, mosi}, {31'd0, b[7 - (t / 2) % 8]});
      chk({req, " R8 busy"}, rdata, 32'h10);
      if (inject && t == 40) begin we = 1'b1; wdata = 32'h10; end
      if (inject && t == 41) we = 1'b0;
      @(negedge clk);
    end
    #1;
    chk({req, " R7 cs end"}, {31'd0, cs_n}, 32'd1);
    chk({req, " R8 busy clear"}, rdata, 32'h0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      chk({req, " R10 no second window"}, {31'd0, cs_n}, 32'd1);
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 cs", {31'd0, cs_n}, 32'd1);
    chk("R1 sck", {31'd0, sck}, 32'd0);
    rd("R1 cmd", 4'd0, 32'h0);
    rd("R1 cfg", 4'd1, 32'h0);
    rd("R1 stat", 4'd9, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    wr(4'd1, 32'hA0);
    rd("R3 cfg bits 7,5", 4'd1, 32'hA0);
    wr(4'd2, 32'h02);
    wr(4'd3, 32'h56);
    wr(4'd4, 32'h34);
    wr(4'd5, 32'h12);
    wr(4'd6, 32'h9A);
    wr(4'd7, 32'hC3);

    // R4 byte mode, 3-byte address
    exp_q = '{8'h02, 8'h12, 8'h34, 8'h56, 8'hC3};
    wr(4'd0, 32'h10);
    run_xfer("R4", 1'b0);

    // R5 4-byte address; R10 go during transfer
    wr(4'd1, 32'hA4);
    rd("R3 cfg bit 2", 4'd1, 32'hA4);
    exp_q = '{8'h02, 8'h9A, 8'h12, 8'h34, 8'h56, 8'hC3};
    wr(4'd0, 32'h10);
    run_xfer("R5 R10", 1'b1);

    // R2 handshake
    wr(4'd1, 32'hA5);
    rd("R2 enable not yet", 4'd1, 32'hA4);
    @(negedge clk);
    rd("R2 enable confirmed", 4'd1, 32'hA5);

    // R9 short queue
    for (int i = 0; i < 31; i++) push_word(32'h1000 + i);
    rd("R9 count 31", 4'd9, 32'h1F00);
    wr(4'd0, 32'h10);
    for (int k = 0; k < 20; k++) begin
      #1;
      chk("R9 no window", {31'd0, cs_n}, 32'd1);
      @(negedge clk);
    end
    rd("R9 flag and empty", 4'd9, 32'h1);
    model_fifo.delete();
    wr(4'd9, 32'h1);
    rd("R9 flag cleared", 4'd9, 32'h0);

    // R11 overflow, R6 page with 4-byte address
    for (int i = 0; i < 33; i++) push_word({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    rd("R11 count full", 4'd9, 32'h2000);
    exp_q = '{8'h02, 8'h9A, 8'h12, 8'h34, 8'h56};
    load_page_bytes();
    wr(4'd0, 32'h10);
    run_xfer("R6 R11", 1'b0);
    rd("R6 queue drained", 4'd9, 32'h0);

    // R6 page with 3-byte address, distinct lane pattern
    wr(4'd1, 32'hA1);
    @(negedge clk);
    for (int i = 0; i < 32; i++) push_word(32'hA55A_0F00 ^ (i * 32'h0103_0507));
    exp_q = '{8'h02, 8'h12, 8'h34, 8'h56};
    load_page_bytes();
    wr(4'd0, 32'h10);
    run_xfer("R6", 1'b0);

    // R2 clearing
    wr(4'd1, 32'hA0);
    rd("R2 disable not yet", 4'd1, 32'hA1);
    @(negedge clk);
    rd("R2 disable confirmed", 4'd1, 32'hA0);

    summary();
  end
endmodule